// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is an 8-bit binary down-counter paced by one of four slow tick strobes. Software stores a reload value, turns the countdown on or off, chooses which tick strobe paces it, and picks whether expiry raises a lasting interrupt or a short repeating one. On expiry the timer flag is set and the counter reloads, so the expiry period is the reload value divided by the rate of the chosen tick.

The tick strobes come from a divider outside the block. Each is a single-cycle enable in the system clock domain, nominally 4096 Hz, 64 Hz, 1 Hz and one per minute. The live count is always visible on an output and the counter never pauses while it is being observed. Software that samples it through a slower path should therefore take two readings and accept them only when they agree.

All register writes share one data bus. Each write is selected by its own strobe, and only one strobe is active in any cycle.

Top module: `cdt_timer`

## Requirements
- R1: After synchronous reset the count, timer flag and interrupt are all 0, the timer is stopped, the reload value is 0, the tick source is 0 and the mode is single-shot.
- R2: The control write takes the run bit from `wdata[7]` and the source from `wdata[1:0]` (0 = 4096 Hz, 1 = 64 Hz, 2 = 1 Hz, 3 = 1/60 Hz). Only `tick_in[source]` advances the counter; the other tick bits have no effect.
- R3: After a reload write, or after a control write that turns a stopped timer on, the first selected tick loads the reload value into the count without decrementing. Each later tick lowers the count by one.
- R4: A selected tick that finds the count at 1 reloads the count from the stored value and sets the timer flag. The interval between expiries is therefore the reload value in ticks.
- R5: In single-shot mode (`wdata[0]` = 0 on a mode write) expiry stops the timer, and the count then holds the reload value. The interrupt output equals the timer flag.
- R6: In periodic mode (`wdata[0]` = 1 on a mode write) the timer keeps running after expiry. The interrupt output is high from the expiry tick until the next selected tick.
- R7: With a reload value of 0 the count stays 0, and neither the flag nor the interrupt is raised, however many ticks arrive.
- R8: While the timer is stopped, ticks leave the count unchanged.
- R9: A pulse on `clr_flag` clears the timer flag. If expiry happens in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 4 | Single-cycle tick enables, one per source |
| wdata | input | 8 | Shared register write data |
| wr_ctrl | input | 1 | Write run bit and tick source |
| wr_mode | input | 1 | Write single-shot/periodic mode |
| wr_reload | input | 1 | Write reload value and re-arm the countdown |
| clr_flag | input | 1 | Clear the timer flag |
| count_out | output | 8 | Live counter value |
| flag_out | output | 1 | Timer flag |
| irq_out | output | 1 | Interrupt line |

## Verification
The bench targets ticks on unselected sources, which a design with a broken select would count. It checks a reload of 1, where every selected tick expires and a periodic interrupt must stay high across ticks. It also checks a reload of 0, which a naive decrement would wrap to 255. A clear that collides with expiry would lose the flag if the priority were inverted. The bench also covers a reload write in the middle of a countdown, which must restart without an off-by-one decrement, and a single-shot expiry, after which a design that failed to stop the timer would keep counting.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int CNT_W   = 8;
    localparam int NSRC    = 4;
    localparam int SEL_W   = $clog2(NSRC);
    localparam int RUN_BIT = CNT_W - 1;
    localparam int PER_BIT = 0;

    typedef enum logic [SEL_W-1:0] {
        SRC_4096HZ = 2'd0,
        SRC_64HZ   = 2'd1,
        SRC_1HZ    = 2'd2,
        SRC_1PMIN  = 2'd3
    } src_e;

    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] src;
        logic             periodic;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             expire;
    } step_t;

    // Next counter value for one consumed tick.
    function automatic step_t count_step(input logic [CNT_W-1:0] cur,
                                         input logic [CNT_W-1:0] reload,
                                         input logic             load);
        step_t s;
        s.value  = cur;
        s.expire = 1'b0;
        if (load) begin
            s.value = reload;
        end else if (cur == CNT_W'(1)) begin
            s.value  = reload;
            s.expire = 1'b1;
        end else if (cur != '0) begin
            s.value = cur - CNT_W'(1);
        end
        return s;
    endfunction

endpackage

// File: rtl/cdt_tick_select.sv
module cdt_tick_select
    import cdt_pkg::*;
(
    input  logic [NSRC-1:0]  tick_in,
    input  logic [SEL_W-1:0] src,
    output logic             tick_sel
);

    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = tick_in[g] && (src == SEL_W'(g));
    end

    assign tick_sel = |hit;

endmodule

// File: rtl/cdt_ctrl_regs.sv
module cdt_ctrl_regs
    import cdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] wdata,
    input  logic             wr_ctrl,
    input  logic             wr_mode,
    input  logic             wr_reload,
    input  logic             consume,
    input  logic             expire,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload,
    output logic             load_pend
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic             pend_q;
    logic             turn_on;

    assign turn_on = wr_ctrl && wdata[RUN_BIT] && !ctrl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run <= wdata[RUN_BIT];
                ctrl_q.src <= wdata[SEL_W-1:0];
            end else if (expire && !ctrl_q.periodic) begin
                ctrl_q.run <= 1'b0;
            end
            if (wr_mode) begin
                ctrl_q.periodic <= wdata[PER_BIT];
            end
            if (wr_reload) begin
                reload_q <= wdata;
            end
            pend_q <= wr_reload || turn_on || (pend_q && !consume);
        end
    end

    assign ctrl      = ctrl_q;
    assign reload    = reload_q;
    assign load_pend = pend_q;

    assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (rst)
        expire && !ctrl_q.periodic && !wr_ctrl |=> !ctrl_q.run);

    assert_rearm_on_write_R3: assert property (@(posedge clk) disable iff (rst)
        wr_reload |=> pend_q && reload_q == $past(wdata));

endmodule

// File: rtl/cdt_count_core.sv
module cdt_count_core
    import cdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             load_pend,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    step_t            nxt;

    assign nxt    = count_step(cnt_q, reload, load_pend);
    assign expire = step && nxt.expire;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= nxt.value;
        end
    end

    assign count = cnt_q;

    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt_q));

    assert_down_by_one_R3: assert property (@(posedge clk) disable iff (rst)
        step && !load_pend && cnt_q > CNT_W'(1) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    assert_reload_on_expiry_R4: assert property (@(posedge clk) disable iff (rst)
        expire |=> cnt_q == $past(reload));

    assert_zero_idle_R7: assert property (@(posedge clk) disable iff (rst)
        reload == '0 && !load_pend |-> !expire);

endmodule

// File: rtl/cdt_irq_gen.sv
module cdt_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic tick_sel,
    input  logic clr_flag,
    input  logic periodic,
    output logic flag,
    output logic irq
);

    logic flag_q;
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (expire)        flag_q <= 1'b1;
            else if (clr_flag) flag_q <= 1'b0;
            if (expire)        pulse_q <= 1'b1;
            else if (tick_sel) pulse_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign irq  = periodic ? pulse_q : flag_q;

    assert_flag_on_expiry_R4: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);

    assert_clear_wins_alone_R9: assert property (@(posedge clk) disable iff (rst)
        clr_flag && !expire |=> !flag_q);

    assert_pulse_one_tick_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_q && tick_sel && !expire |=> !pulse_q);

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  tick_in,
    input  logic [CNT_W-1:0] wdata,
    input  logic             wr_ctrl,
    input  logic             wr_mode,
    input  logic             wr_reload,
    input  logic             clr_flag,
    output logic [CNT_W-1:0] count_out,
    output logic             flag_out,
    output logic             irq_out
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic             load_pend;
    logic             tick_sel;
    logic             consume;
    logic             expire;

    cdt_tick_select u_sel (
        .tick_in  (tick_in),
        .src      (ctrl.src),
        .tick_sel (tick_sel)
    );

    assign consume = tick_sel && ctrl.run;

    cdt_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wdata     (wdata),
        .wr_ctrl   (wr_ctrl),
        .wr_mode   (wr_mode),
        .wr_reload (wr_reload),
        .consume   (consume),
        .expire    (expire),
        .ctrl      (ctrl),
        .reload    (reload),
        .load_pend (load_pend)
    );

    cdt_count_core u_core (
        .clk       (clk),
        .rst       (rst),
        .step      (consume),
        .load_pend (load_pend),
        .reload    (reload),
        .count     (count_out),
        .expire    (expire)
    );

    cdt_irq_gen u_irq (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .tick_sel (tick_sel),
        .clr_flag (clr_flag),
        .periodic (ctrl.periodic),
        .flag     (flag_out),
        .irq      (irq_out)
    );

    assert_unselected_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_in[ctrl.src] |=> $stable(count_out));

endmodule

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] tick_in = '0;
    logic [7:0] wdata = '0;
    logic       wr_ctrl = 1'b0, wr_mode = 1'b0, wr_reload = 1'b0, clr_flag = 1'b0;
    logic [7:0] count_out;
    logic       flag_out, irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    logic [7:0] m_cnt, m_rel;
    logic [1:0] m_src;
    logic       m_run, m_per, m_pend, m_flag, m_pulse;

    always #2 clk = ~clk;

    cdt_timer dut (
        .clk(clk), .rst(rst), .tick_in(tick_in), .wdata(wdata),
        .wr_ctrl(wr_ctrl), .wr_mode(wr_mode), .wr_reload(wr_reload),
        .clr_flag(clr_flag), .count_out(count_out), .flag_out(flag_out),
        .irq_out(irq_out)
    );

    function automatic logic exp_irq();
        return m_per ? m_pulse : m_flag;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_rel = 0; m_src = 0; m_run = 0; m_per = 0;
        m_pend = 0; m_flag = 0; m_pulse = 0;
    endtask

    task automatic model_step();
        logic sel, use_t, exp_t;
        logic [7:0] ncnt;
        sel   = tick_in[m_src];
        use_t = sel && m_run;
        exp_t = 0;
        ncnt  = m_cnt;
        if (use_t) begin
            if (m_pend) ncnt = m_rel;
            else if (m_cnt == 8'd1) begin ncnt = m_rel; exp_t = 1; end
            else if (m_cnt != 0) ncnt = m_cnt - 8'd1;
        end
        m_pend = wr_reload || (wr_ctrl && wdata[7] && !m_run) || (m_pend && !use_t);
        if (wr_ctrl) begin m_run = wdata[7]; m_src = wdata[1:0]; end
        else if (exp_t && !m_per) m_run = 0;
        if (wr_mode) m_per = wdata[0];
        if (wr_reload) m_rel = wdata;
        if (exp_t) m_flag = 1; else if (clr_flag) m_flag = 0;
        if (exp_t) m_pulse = 1; else if (sel) m_pulse = 0;
        m_cnt = ncnt;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        chk("R3 count", count_out, m_cnt);
        chk("R4 flag", flag_out, m_flag);
        chk("R6 irq", irq_out, exp_irq());
        tick_in = '0; wr_ctrl = 0; wr_mode = 0; wr_reload = 0; clr_flag = 0;
    endtask

    task automatic do_reload(input logic [7:0] v);
        wdata = v; wr_reload = 1; cyc();
    endtask
    task automatic do_ctrl(input logic run, input logic [1:0] src);
        wdata = {run, 5'b0, src}; wr_ctrl = 1; cyc();
    endtask
    task automatic do_mode(input logic per);
        wdata = {7'b0, per}; wr_mode = 1; cyc();
    endtask
    task automatic do_tick(input logic [3:0] t);
        tick_in = t; cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        model_reset();
        @(negedge clk);
        repeat (3) cyc();
        rst = 0;
        chk("R1 count", count_out, 0);
        chk("R1 flag", flag_out, 0);
        chk("R1 irq", irq_out, 0);

        // single-shot, reload 3, source 0
        do_reload(8'd3); do_mode(0); do_ctrl(1, 2'd0);
        do_tick(4'b0001); chk("R3 first tick loads", count_out, 3);
        do_tick(4'b0001); chk("R3 decrement", count_out, 2);
        do_tick(4'b0001); chk("R3 decrement", count_out, 1);
        do_tick(4'b0001); chk("R4 reload", count_out, 3); chk("R4 flag", flag_out, 1);
        chk("R5 irq follows flag", irq_out, 1);
        do_tick(4'b0001); chk("R5 stopped", count_out, 3);
        wdata = 0; clr_flag = 1; cyc();
        chk("R9 clear", flag_out, 0); chk("R5 irq cleared", irq_out, 0);

        // periodic, reload 2, source 2
        do_mode(1); do_reload(8'd2); do_ctrl(1, 2'd2);
        do_tick(4'b1011); chk("R2 other sources ignored", count_out, 3);
        do_tick(4'b0100); chk("R2 selected loads", count_out, 2);
        do_tick(4'b0100); chk("R3 decrement", count_out, 1);
        do_tick(4'b0100); chk("R6 keeps running", count_out, 2); chk("R6 irq high", irq_out, 1);
        do_tick(4'b0000); chk("R6 irq held", irq_out, 1);
        do_tick(4'b0100); chk("R6 irq one tick", irq_out, 0); chk("R6 count", count_out, 1);

        // collision of clear and expiry
        tick_in = 4'b0100; clr_flag = 1; cyc();
        chk("R9 set wins", flag_out, 1);

        // stopped
        do_ctrl(0, 2'd2);
        do_tick(4'b0100); do_tick(4'b0100);
        chk("R8 frozen", count_out, 2);

        // reload zero
        do_reload(8'd0); do_ctrl(1, 2'd2);
        wdata = 0; clr_flag = 1; cyc();
        for (int i = 0; i < 6; i++) do_tick(4'b0100);
        chk("R7 idle count", count_out, 0); chk("R7 no flag", flag_out, 0);
        chk("R7 no irq", irq_out, 0);

        // reload 1 periodic: every tick expires
        do_reload(8'd1); do_tick(4'b0100);
        do_tick(4'b0100); chk("R4 reload one", flag_out, 1);
        do_tick(4'b0100); chk("R6 irq stays", irq_out, 1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 3) begin
                wdata = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 6);
                wr_reload = 1;
            end else if (r < 5) begin
                wdata = {($urandom % 4 != 0), 5'($urandom), 2'($urandom)};
                wr_ctrl = 1;
            end else if (r < 6) begin
                wdata = 8'($urandom); wr_mode = 1;
            end else if (r < 9) begin
                clr_flag = 1;
            end
            for (int b = 0; b < 4; b++) tick_in[b] = ($urandom % 3 == 0);
            cyc();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule